// File: doc/BRIEF.md
# Runtime-Configurable Comb Differentiator Chain

This block is the differentiating back end of a cascaded integrator-comb decimator. It takes the 26-bit signed word produced once per output sample by the decimation stage and passes it through five differentiators in series. Each differentiator subtracts the value it saw at the previous decimated-rate sample from the value it sees now. Between stages the word is narrowed by discarding least-significant bits, so the chain ends in a 19-bit signed word that feeds a downstream rounder.

The filter order is chosen at run time with a small stage-count field. The first `stages` differentiators are active. Every other differentiator has its delay register held at zero, so it passes its input unchanged apart from truncation. A bypass input makes every stage pass data through in this way. All state advances only on a decimated-rate enable strobe. The result is registered, and a one-cycle valid strobe accompanies it.

Top module: `comb_decim`

## Requirements
- R1: Each active stage outputs its input minus the input it held at the previous enabled sample. The subtraction is two's complement and wraps modulo that stage's width.
- R2: Stage arithmetic widths are 26, 22, 21, 20 and 19 bits in chain order. Each stage passes to the next the most-significant bits of its difference, so LSBs are dropped and the sign is kept. The 19-bit output is the last stage's difference.
- R3: Delay registers and the output register change only in clock cycles where `dec_en` is high. While `dec_en` is low, `dout` holds its value.
- R4: A `stages` value k activates stages 1..k only. A value of 0 activates none, and any value of 5 or more activates all five. A stage that is not active holds its delay register at zero, so its first difference after re-activation is taken against zero.
- R5: While `bypass` is high, no stage is active and every delay register is zero. The output one cycle after an enable equals `din[25:7]` from that enable cycle.
- R6: `dout` and `dout_vld` are registered. `dout_vld` is high for exactly the cycle after each cycle with `dec_en` high, and `dout` then carries the chain result computed from that cycle's inputs.
- R7: Driving `rst_n` low clears every delay register, `dout` and `dout_vld` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | Decimated-rate sample strobe |
| bypass | input | 1 | Forces every stage to pass data through |
| stages | input | 3 | Number of active leading stages (0 to 5; larger means 5) |
| din | input | 26 | Signed word from the decimation register |
| dout | output | 19 | Signed chain result to the rounder |
| dout_vld | output | 1 | High in the cycle that `dout` is updated |

## Verification
The case that is hardest to reach is a stage that was switched off while holding history and is then switched back on. That stage must compare against zero instead of its stale value, and this can only be seen at the output once the stages behind it have also settled. The stimulus holds a stage count long enough to build history, lowers it, leaves `dec_en` idle for some cycles, and raises it again. The random phase also changes the count and bypass in bursts between sparse enables, so many such transitions occur. Full-scale inputs of opposite sign are sent back to back to force wrap-around in the first stage.

// File: rtl/comb_pkg.sv
package comb_pkg;

  // Stage idx (0-based) is active when not bypassed and idx < count.
  function automatic logic stage_on(input int unsigned idx,
                                    input int unsigned cnt,
                                    input logic        byp);
    return !byp && (idx < cnt);
  endfunction

endpackage

// File: rtl/comb_ctrl.sv
module comb_ctrl #(
  parameter int N_STAGES = 5,
  parameter int CNT_W    = $clog2(N_STAGES + 1)
) (
  input  logic                bypass,
  input  logic [CNT_W-1:0]    stages,
  output logic [N_STAGES-1:0] act
);

  for (genvar g = 0; g < N_STAGES; g++) begin : g_act
    assign act[g] = comb_pkg::stage_on(g, int'(stages), bypass);
  end

endmodule

// File: rtl/comb_stage.sv
module comb_stage #(
  parameter int WI = 26,
  parameter int WO = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_en,
  input  logic          active,
  input  logic [WI-1:0] din,
  output logic [WO-1:0] dout
);

  logic [WI-1:0] dly_q;
  logic [WI-1:0] sub_b;
  logic [WI-1:0] diff;

  function automatic logic [WI-1:0] wrap_sub(input logic [WI-1:0] a,
                                             input logic [WI-1:0] b);
    return a - b;
  endfunction

  function automatic logic [WO-1:0] keep_msbs(input logic [WI-1:0] v);
    return v[WI-1 -: WO];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dly_q <= '0;
    else if (!active) dly_q <= '0;
    else if (dec_en)  dly_q <= din;
  end

  assign sub_b = active ? dly_q : '0;
  assign diff  = wrap_sub(din, sub_b);
  assign dout  = keep_msbs(diff);

endmodule

// File: rtl/comb_decim.sv
module comb_decim #(
  parameter int N_STAGES           = 5,
  parameter int STAGE_W [N_STAGES] = '{26, 22, 21, 20, 19},
  parameter int IN_W               = 26,
  parameter int OUT_W              = 19,
  parameter int CNT_W              = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic             bypass,
  input  logic [CNT_W-1:0] stages,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             dout_vld
);

  logic [N_STAGES-1:0] stage_act;
  logic [IN_W-1:0]     link [N_STAGES+1];
  logic [OUT_W-1:0]    chain_out;

  comb_ctrl #(.N_STAGES(N_STAGES), .CNT_W(CNT_W)) u_ctrl (
    .bypass (bypass),
    .stages (stages),
    .act    (stage_act)
  );

  assign link[0] = din;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    localparam int WI = STAGE_W[g];
    localparam int WO = STAGE_W[(g == N_STAGES-1) ? g : g+1];
    logic [WO-1:0] s_out;

    comb_stage #(.WI(WI), .WO(WO)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .dec_en (dec_en),
      .active (stage_act[g]),
      .din    (link[g][WI-1:0]),
      .dout   (s_out)
    );

    assign link[g+1] = IN_W'(s_out);
  end

  assign chain_out = link[N_STAGES][OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= dec_en;
      if (dec_en) dout <= chain_out;
    end
  end

endmodule

// File: rtl/comb_decim_chk.sv
module comb_decim_chk #(
  parameter int N_STAGES = 5,
  parameter int IN_W     = 26,
  parameter int OUT_W    = 19,
  parameter int CNT_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dec_en,
  input logic                bypass,
  input logic [CNT_W-1:0]    stages,
  input logic [IN_W-1:0]     din,
  input logic [OUT_W-1:0]    dout,
  input logic                dout_vld,
  input logic [N_STAGES-1:0] stage_act
);

  assert_vld_follows_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> dout_vld);

  assert_vld_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> !dout_vld);

  assert_hold_no_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> $stable(dout));

  assert_bypass_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && dec_en) |=> dout == $past(din[IN_W-1 -: OUT_W]));

  assert_zero_stages_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stages == '0 && dec_en) |=> dout == $past(din[IN_W-1 -: OUT_W]));

  assert_bypass_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> stage_act == '0);

  assert_full_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && int'(stages) >= N_STAGES) |-> &stage_act);

endmodule

bind comb_decim comb_decim_chk #(
  .N_STAGES(N_STAGES), .IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .bypass(bypass),
  .stages(stages), .din(din), .dout(dout), .dout_vld(dout_vld),
  .stage_act(stage_act)
);

// File: tb/tb_comb_decim.sv
`timescale 1ns/1ps
module tb_comb_decim;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        dec_en = 1'b0;
  logic        bypass = 1'b0;
  logic [2:0]  stages = 3'd0;
  logic [25:0] din = '0;
  logic [18:0] dout;
  logic        dout_vld;

  int n_checks = 0;
  int n_fail   = 0;

  int     W [5] = '{26, 22, 21, 20, 19};
  longint mdly [5];
  longint exp_dout;
  bit     exp_vld;

  always #4 clk = ~clk;

  comb_decim dut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .bypass(bypass),
    .stages(stages), .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic longint wrapw(longint v, int w);
    longint m;
    m = v & ((longint'(1) <<< w) - 1);
    if (m[w-1]) m = m - (longint'(1) <<< w);
    return m;
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 5; i++) mdly[i] = 0;
    exp_dout = 0;
    exp_vld  = 0;
  endfunction

  function automatic void model_step(longint x_in, int cnt, bit byp, bit en);
    longint x, d;
    int nw;
    bit act;
    x = x_in;
    for (int i = 0; i < 5; i++) begin
      act = !byp && (i < cnt);
      d   = wrapw(x - (act ? mdly[i] : 0), W[i]);
      nw  = (i < 4) ? W[i+1] : W[4];
      if (!act)    mdly[i] = 0;
      else if (en) mdly[i] = x;
      x = d >>> (W[i] - nw);
    end
    if (en) exp_dout = x;
    exp_vld = en;
  endfunction

  task automatic check(string req, longint act_v, longint exp_v);
    n_checks++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // Called at a falling edge; ends at the next falling edge after checking.
  task automatic tick(string req, logic [25:0] d, int cnt, bit byp, bit en);
    din = d; stages = 3'(cnt); bypass = byp; dec_en = en;
    model_step(longint'($signed(d)), cnt, byp, en);
    @(negedge clk);
    check(req, longint'($signed(dout)), exp_dout);
    check(req, longint'(dout_vld), longint'(exp_vld));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    dec_en = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    check("R7", longint'($signed(dout)), 0);
    check("R7", longint'(dout_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C1C5EE));
    model_clear();
    #1 rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: single stage, step input then constant
    tick("R1", 26'd1000, 1, 0, 1);
    tick("R1", 26'd1000, 1, 0, 1);
    tick("R1", 26'd1000, 1, 0, 1);
    tick("R1", 26'd1300, 1, 0, 1);

    // R2: all stages active, impulse of large value
    do_reset();
    tick("R2", 26'h0ABCDEF, 5, 0, 1);
    for (int i = 0; i < 6; i++) tick("R2", 26'd0, 5, 0, 1);

    // R3: enable low, inputs change, output holds
    tick("R3", 26'h1234567, 5, 0, 1);
    for (int i = 0; i < 4; i++) tick("R3", 26'(i * 77777), 5, 0, 0);
    tick("R3", 26'h1234567, 5, 0, 1);

    // R5: bypass passes MSBs
    tick("R5", 26'h2FEDCBA, 5, 1, 1);
    tick("R5", 26'h1000080, 3, 1, 1);
    check("R5", longint'(dout), longint'(26'h1000080 >> 7));

    // R4: count 0 and counts above 5
    tick("R4", 26'h3000000, 0, 0, 1);
    check("R4", longint'(dout), longint'(26'h3000000 >> 7));
    tick("R4", 26'h0000400, 7, 0, 1);
    tick("R4", 26'h0000400, 6, 0, 1);

    // R4: build history, disable, idle, re-enable compares against zero
    do_reset();
    for (int i = 0; i < 4; i++) tick("R4", 26'(50000 + i * 3000), 3, 0, 1);
    tick("R4", 26'd9000, 1, 0, 1);
    for (int i = 0; i < 3; i++) tick("R4", 26'd0, 1, 0, 0);
    tick("R4", 26'd64000, 3, 0, 1);
    tick("R4", 26'd64000, 3, 0, 1);

    // R1: wrap with full-scale opposite values
    do_reset();
    tick("R1", 26'h2000000, 1, 0, 1);
    tick("R1", 26'h1FFFFFF, 1, 0, 1);
    check("R1", longint'($signed(dout)), -1);
    tick("R1", 26'h2000000, 2, 0, 1);

    // R7: reset in mid-run clears history
    tick("R7", 26'h0123456, 5, 0, 1);
    do_reset();
    tick("R7", 26'h0000800, 1, 0, 1);
    check("R7", longint'($signed(dout)), 16);

    // Random: count and bypass held in bursts, sparse enables
    begin
      int cnt = 5;
      bit byp = 0;
      for (int n = 0; n < 1500; n++) begin
        logic [25:0] d;
        bit en;
        if (n % 16 == 0) begin
          cnt = int'($urandom % 8);
          byp = ($urandom % 8) == 0;
        end
        case ($urandom % 6)
          0: d = 26'h1FFFFFF;
          1: d = 26'h2000000;
          default: d = 26'($urandom);
        endcase
        en = ($urandom % 3) != 0;
        tick((byp ? "R5" : "R2"), d, cnt, byp, en);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule